// File: doc/BRIEF.md
# Bidirectional Token Row-Scan Shift Register

This block selects display rows one at a time. It holds a 40-stage shift register that carries a single active bit, the token. A seed pulse on the active end port empties the register and puts the token into the entry stage. Each rising clock edge then moves the token one stage further. When the token leaves the far end, it appears on the opposite end port, so several devices can be chained into one long scan.

A direction input chooses which end port is the input and which is the cascade output. It also chooses the way the token travels.

Every stage drives one row channel. A channel is given as an enable and a level, so it can drive high, drive low or stay high-impedance. A polarity input picks the driven level, and a blanking input forces every channel to high-impedance.

Top module: `row_token_scanner`

## Requirements
- R1: A rising edge with `rst` high clears every stage and the cascade output. All `row_en` and `row_lvl` bits then read 0.
- R2: With `scan_up` = 1, a rising edge that samples `end_a_in` high loads the token into bit 0 alone. This is the first channel.
- R3: A rising edge with no seed and no reset shifts the token one place. With `scan_up` = 1 it moves toward the higher index, and a 0 enters the entry stage. After the last stage the register is empty.
- R4: With `scan_up` = 0, `end_b_in` is the seed input. The token enters at bit 39 and moves toward bit 0. Changing `scan_up` in mid-run reverses the way an existing token moves.
- R5: The end port that is not the selected input is ignored. A high level on it neither seeds nor clears the register.
- R6: A seed may arrive at any time. It discards any token in flight and restarts at the entry stage.
- R7: The cascade bit copies the exit stage (bit 39 when `scan_up` = 1, bit 0 when `scan_up` = 0) at each falling clock edge. A seed sampled at rising edge k therefore reaches the cascade output at the falling edge after rising edge k+39. It stays there for one clock and is seen by a chained device at rising edge k+40.
- R8: With `scan_up` = 1, `end_a_oe` = 0 and `end_a_out` = 0, while `end_b_oe` = 1 and `end_b_out` carries the cascade bit. With `scan_up` = 0 the roles of the two ports are swapped.
- R9: An enabled channel has `row_lvl` equal to `level_hi`. A disabled channel has `row_lvl` = 0.
- R10: With `blank` = 1, every `row_en` bit is 0, whatever the register holds and whatever the polarity.
- R11: At most one `row_en` bit is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Shifting on the rising edge, cascade update on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_up | input | 1 | 1: port A is the input and the token moves up; 0: port B is the input and the token moves down |
| level_hi | input | 1 | Polarity: 1 drives an active channel high, 0 drives it low |
| blank | input | 1 | 1 forces all channels to high-impedance |
| end_a_in | input | 1 | Port A receive side (seed input when scan_up = 1) |
| end_a_out | output | 1 | Port A transmit value (cascade when scan_up = 0) |
| end_a_oe | output | 1 | Port A transmit enable |
| end_b_in | input | 1 | Port B receive side (seed input when scan_up = 0) |
| end_b_out | output | 1 | Port B transmit value (cascade when scan_up = 1) |
| end_b_oe | output | 1 | Port B transmit enable |
| row_en | output | 40 | Per-channel drive enable (0 = high-impedance) |
| row_lvl | output | 40 | Per-channel driven level |

## Verification
A seed, shift or reset sampled at one rising edge shows on `row_en` and `row_lvl` straight after that edge. Polarity, blanking and direction reach the channel and port-enable outputs combinationally, with no clock at all. The cascade value is due half a clock after the rising edge, at the falling edge.

The bench changes inputs 2 ns after each rising edge and samples 8 ns after it. At that point the falling-edge update has happened, the next rising edge has not, and the level and steering inputs have settled. The expected value for each sample is queued when its stimulus is applied and compared in that window.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

    typedef enum logic {
        SCAN_DOWN = 1'b0,
        SCAN_UP   = 1'b1
    } scan_dir_e;

    typedef struct packed {
        logic en;
        logic lvl;
    } chan_drive_t;

    typedef struct packed {
        logic a_out;
        logic a_oe;
        logic b_out;
        logic b_oe;
    } port_drive_t;

    // Picks the value belonging to the end selected by the direction.
    function automatic logic pick_end(scan_dir_e d, logic when_up, logic when_down);
        return (d == SCAN_UP) ? when_up : when_down;
    endfunction

endpackage

// File: rtl/token_shifter.sv
module token_shifter
    import row_scan_pkg::*;
#(
    parameter int unsigned STAGES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  scan_dir_e         dir,
    input  logic              seed,
    output logic [STAGES-1:0] stages,
    output logic              exit_bit
);
    localparam logic [STAGES-1:0] LOW_ONE  = {{(STAGES-1){1'b0}}, 1'b1};
    localparam logic [STAGES-1:0] HIGH_ONE = LOW_ONE << (STAGES-1);

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else if (seed) begin
            stages <= (dir == SCAN_UP) ? LOW_ONE : HIGH_ONE;
        end else if (dir == SCAN_UP) begin
            stages <= {stages[STAGES-2:0], 1'b0};
        end else begin
            stages <= {1'b0, stages[STAGES-1:1]};
        end
    end

    assign exit_bit = pick_end(dir, stages[STAGES-1], stages[0]);

    // R2: an upward seed lands in the lowest stage
    p_seed_up_r2: assert property (@(posedge clk) disable iff (rst)
        (seed && dir == SCAN_UP) |=> (stages == LOW_ONE));

    // R4: a downward seed lands in the highest stage
    p_seed_down_r4: assert property (@(posedge clk) disable iff (rst)
        (seed && dir == SCAN_DOWN) |=> (stages == HIGH_ONE));

    // R3: shifting never invents a token
    p_no_new_token_r3: assert property (@(posedge clk) disable iff (rst)
        (!seed && stages == '0) |=> (stages == '0));

    // R11: the register never holds more than one token
    p_single_token_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stages));

endmodule

// File: rtl/cascade_tap.sv
module cascade_tap (
    input  logic clk,
    input  logic rst,
    input  logic exit_bit,
    output logic casc
);
    // Falling-edge capture: the chained device sees a stable value at its next rise.
    always_ff @(negedge clk) begin
        if (rst) casc <= 1'b0;
        else     casc <= exit_bit;
    end

    // R7: a new cascade pulse lasts one clock because the token moves on
    p_casc_one_clock_r7: assert property (@(negedge clk) disable iff (rst)
        $rose(casc) |=> !casc);

endmodule

// File: rtl/channel_decoder.sv
module channel_decoder
    import row_scan_pkg::*;
#(
    parameter int unsigned STAGES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] stages,
    input  logic              level_hi,
    input  logic              blank,
    output logic [STAGES-1:0] en_vec,
    output logic [STAGES-1:0] lvl_vec
);
    chan_drive_t drv [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_chan
        always_comb begin
            drv[i].en  = stages[i] & ~blank;
            drv[i].lvl = stages[i] & ~blank & level_hi;
        end
        assign en_vec[i]  = drv[i].en;
        assign lvl_vec[i] = drv[i].lvl;
    end

    // R10: blanking leaves every channel undriven
    p_blank_hiz_r10: assert property (@(posedge clk) disable iff (rst)
        blank |-> (en_vec == '0));

    // R9: driven level matches polarity on enabled channels, 0 elsewhere
    p_level_pol_r9: assert property (@(posedge clk) disable iff (rst)
        lvl_vec == (level_hi ? en_vec : '0));

endmodule

// File: rtl/port_steer.sv
module port_steer
    import row_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  scan_dir_e   dir,
    input  logic        a_in,
    input  logic        b_in,
    input  logic        casc,
    output logic        seed,
    output port_drive_t pd
);
    always_comb begin
        seed     = pick_end(dir, a_in, b_in);
        pd.a_oe  = (dir == SCAN_DOWN);
        pd.b_oe  = (dir == SCAN_UP);
        pd.a_out = pd.a_oe & casc;
        pd.b_out = pd.b_oe & casc;
    end

    // R8: the input-side port is never driven
    p_in_side_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (dir == SCAN_UP) |-> (!pd.a_oe && !pd.a_out));

    p_in_side_quiet_dn_r8: assert property (@(posedge clk) disable iff (rst)
        (dir == SCAN_DOWN) |-> (!pd.b_oe && !pd.b_out));

endmodule

// File: rtl/row_token_scanner.sv
module row_token_scanner
    import row_scan_pkg::*;
#(
    parameter int unsigned NUM_ROWS = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_up,
    input  logic                level_hi,
    input  logic                blank,
    input  logic                end_a_in,
    output logic                end_a_out,
    output logic                end_a_oe,
    input  logic                end_b_in,
    output logic                end_b_out,
    output logic                end_b_oe,
    output logic [NUM_ROWS-1:0] row_en,
    output logic [NUM_ROWS-1:0] row_lvl
);
    scan_dir_e            dir;
    logic                 seed;
    logic                 exit_bit;
    logic                 casc;
    logic [NUM_ROWS-1:0]  stages;
    port_drive_t          pd;

    assign dir = scan_dir_e'(scan_up);

    port_steer u_steer (
        .clk(clk), .rst(rst), .dir(dir), .a_in(end_a_in), .b_in(end_b_in),
        .casc(casc), .seed(seed), .pd(pd)
    );

    token_shifter #(.STAGES(NUM_ROWS)) u_shift (
        .clk(clk), .rst(rst), .dir(dir), .seed(seed),
        .stages(stages), .exit_bit(exit_bit)
    );

    cascade_tap u_tap (
        .clk(clk), .rst(rst), .exit_bit(exit_bit), .casc(casc)
    );

    channel_decoder #(.STAGES(NUM_ROWS)) u_dec (
        .clk(clk), .rst(rst), .stages(stages), .level_hi(level_hi),
        .blank(blank), .en_vec(row_en), .lvl_vec(row_lvl)
    );

    assign end_a_out = pd.a_out;
    assign end_a_oe  = pd.a_oe;
    assign end_b_out = pd.b_out;
    assign end_b_oe  = pd.b_oe;

    // R11: never more than one channel driven
    p_one_channel_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_en));

    // R1: the cycle after a reset edge shows no driven channel
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (row_en == '0));

endmodule

// File: tb/row_token_scanner_bench.sv
module row_token_scanner_bench;
    localparam int N = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_up = 1'b1, level_hi = 1'b1, blank = 1'b0;
    logic end_a_in = 1'b0, end_b_in = 1'b0;
    logic end_a_out, end_a_oe, end_b_out, end_b_oe;
    logic [N-1:0] row_en, row_lvl;

    always #5 clk = ~clk;

    row_token_scanner #(.NUM_ROWS(N)) u_row_token_scanner (
        .clk(clk), .rst(rst), .scan_up(scan_up), .level_hi(level_hi), .blank(blank),
        .end_a_in(end_a_in), .end_a_out(end_a_out), .end_a_oe(end_a_oe),
        .end_b_in(end_b_in), .end_b_out(end_b_out), .end_b_oe(end_b_oe),
        .row_en(row_en), .row_lvl(row_lvl)
    );

    typedef struct {
        logic [N-1:0] en;
        logic [N-1:0] lvl;
        logic a_out, a_oe, b_out, b_oe;
        string tag;
    } exp_t;

    exp_t sb[$];
    int tok = -1;
    int vectors = 0;
    int misses = 0;
    bit done = 0;

    // Driver: apply inputs, queue the expected sample, advance the model.
    task automatic step(input logic r, input logic up, input logic ai, input logic bi,
                        input logic hi, input logic bl, input string tag);
        exp_t e;
        logic [N-1:0] one;
        logic casc;
        @(posedge clk);
        #2;
        rst = r; scan_up = up; end_a_in = ai; end_b_in = bi; level_hi = hi; blank = bl;
        one = '0;
        if (tok >= 0) one[tok] = 1'b1;
        casc = !r && (tok >= 0) && (tok == (up ? N-1 : 0));
        e.en    = bl ? '0 : one;
        e.lvl   = hi ? e.en : '0;
        e.a_oe  = !up;
        e.b_oe  = up;
        e.a_out = !up && casc;
        e.b_out = up && casc;
        e.tag   = tag;
        sb.push_back(e);
        if (r) tok = -1;
        else if (up ? ai : bi) tok = up ? 0 : N-1;
        else if (tok >= 0) begin
            tok = up ? tok + 1 : tok - 1;
            if (tok < 0 || tok >= N) tok = -1;
        end
    endtask

    task automatic run(input int n, input logic up, input logic hi, input logic bl,
                       input string tag);
        for (int i = 0; i < n; i++) step(1'b0, up, 1'b0, 1'b0, hi, bl, tag);
    endtask

    // Monitor: compare each queued item in the mid-cycle window.
    initial begin
        forever begin
            @(posedge clk);
            #8;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                if (row_en !== e.en) begin
                    misses++;
                    $display("FAIL %s row_en got %h exp %h", e.tag, row_en, e.en);
                end
                if (row_lvl !== e.lvl) begin
                    misses++;
                    $display("FAIL R9 (%s) row_lvl got %h exp %h", e.tag, row_lvl, e.lvl);
                end
                if ({end_a_out, end_a_oe, end_b_out, end_b_oe} !==
                    {e.a_out, e.a_oe, e.b_out, e.b_oe}) begin
                    misses++;
                    $display("FAIL R8/R7 (%s) ports got %b exp %b", e.tag,
                             {end_a_out, end_a_oe, end_b_out, end_b_oe},
                             {e.a_out, e.a_oe, e.b_out, e.b_oe});
                end
                vectors++;
                if ($countones(row_en) > 1) begin
                    misses++;
                    $display("FAIL R11 row_en got %h exp at most one bit", row_en);
                end
            end
        end
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        // R2, R3, R7: upward seed on port A and a full pass out through port B
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
        run(43, 1'b1, 1'b1, 1'b0, "R3_R7");
        // R4: downward seed on port B, low polarity, full pass out through port A
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        run(43, 1'b0, 1'b0, 1'b0, "R4_R7");
        // R5: the unselected port does not seed, with the register empty
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        run(3, 1'b1, 1'b1, 1'b0, "R5");
        // R5: the unselected port does not clear a token in flight
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
        run(4, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        run(3, 1'b1, 1'b1, 1'b0, "R5");
        // R6: reseed in mid-run restarts at the entry stage
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
        run(10, 1'b1, 1'b1, 1'b0, "R6");
        // R9, R10: polarity and blanking while the token moves
        run(4, 1'b1, 1'b0, 1'b0, "R9");
        run(4, 1'b1, 1'b1, 1'b1, "R10");
        run(4, 1'b1, 1'b0, 1'b1, "R10");
        // R4: a direction change reverses the token
        run(6, 1'b0, 1'b1, 1'b0, "R4");
        run(3, 1'b1, 1'b1, 1'b0, "R4");
        // R1: reset in mid-run
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
        run(3, 1'b1, 1'b1, 1'b0, "R1");
        // R7: downward pass again with blanking, cascade still runs
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
        run(42, 1'b0, 1'b1, 1'b1, "R7");
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule